// File: doc/BRIEF.md
# Clock Status and Interrupt Flag Register

This block is the status and flag register of a clock-generation unit. It registers two status inputs: the PLL lock indication and the oscillator-qualified indication. A change in either one, rising or falling, sets a sticky change flag. Two more sticky flags record the cause of a reset: a low-voltage reset and an illegal-address reset. Software reads all six bits through one register and clears any flag by writing 1 to its bit. When a change flag is set and its enable input is high, the block drives a level interrupt request.

The block also applies two safety rules that follow from these status bits. While the PLL is unlocked, the post-divider ratio is forced to a fixed safe value; once the PLL locks, the configured value plus one is used. The oscillator clock enable toward the CAN peripheral is held low until the oscillator is qualified. The oscillator-qualified status is dropped on entry to full stop. It is also dropped whenever lock is missing, except while pseudo stop is indicated.

The register port is a plain write strobe with a combinational read value. There is no data stream here, so there is no valid/ready handshake and no back-pressure: a write is accepted in the cycle its strobe is high.

Top module: `clk_stat_flags`

## Requirements
- R1: Read value layout: bit 5 low-voltage reset flag, bit 4 lock-change flag, bit 3 lock status, bit 2 illegal-address reset flag, bit 1 oscillator-change flag, bit 0 oscillator-qualified status. Bits 7 and 6 always read 0.
- R2: The lock status bit equals `pll_lock_in` as sampled at the previous clock edge. Writes have no effect on it.
- R3: The oscillator-qualified bit becomes 1 at an edge only if `osc_qual_in` is 1, `full_stop` is 0, and either `pll_lock_in` or `pseudo_stop` is 1. Otherwise it becomes 0. Writes have no effect on it.
- R4: The lock-change flag is set at every edge where the lock status bit changes, in either direction.
- R5: The oscillator-change flag is set at every edge where the oscillator-qualified bit changes, in either direction.
- R6: A pulse on `lvr_evt` sets bit 5, and a pulse on `iladdr_evt` sets bit 2. Both flags stay set until they are cleared.
- R7: Writing 1 to bit 5, 4, 2 or 1 clears that flag. Writing 0 leaves it unchanged.
- R8: If a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up 1.
- R9: `irq` is high exactly when (lock-change flag AND `lock_ie`) OR (oscillator-change flag AND `osc_ie`) is true.
- R10: `pll_div_ratio` is 4 while the lock status bit is 0, and `postdiv_cfg`+1 while it is 1.
- R11: `can_osc_en` equals the oscillator-qualified bit, so it is 0 whenever that bit is 0.
- R12: After reset, the read value is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Write data; a 1 in a flag position clears that flag |
| reg_rd_data | output | 8 | Register read value |
| pll_lock_in | input | 1 | PLL lock indication |
| osc_qual_in | input | 1 | Oscillator qualified indication from the filter |
| lvr_evt | input | 1 | Low-voltage reset event pulse |
| iladdr_evt | input | 1 | Illegal-address reset event pulse |
| full_stop | input | 1 | Full stop mode indication |
| pseudo_stop | input | 1 | Pseudo stop mode indication |
| lock_ie | input | 1 | Lock-change interrupt enable |
| osc_ie | input | 1 | Oscillator-change interrupt enable |
| postdiv_cfg | input | 5 | Configured post-divider value |
| pll_div_ratio | output | 6 | Effective PLL output divide ratio |
| can_osc_en | output | 1 | Oscillator clock enable toward the CAN peripheral |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that every input is already synchronous to `clk`. They also assume that an event pulse or a write strobe stands for exactly one cycle of intent, so two consecutive high cycles count as two events. They make no assumption about how status inputs and mode indications are combined. Full stop, pseudo stop, a loss of lock and a clearing write may all occur in the same cycle. The stimulus drives every input one nanosecond after the rising edge. It mixes random toggling with directed cases: a clear colliding with a set, pseudo stop during loss of lock, and full stop while locked.

// File: rtl/csf_pkg.sv
package csf_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_FLAGS = 4;

  // Bit positions within the read value
  localparam int POS_OSC   = 0;
  localparam int POS_OSCF  = 1;
  localparam int POS_ILA   = 2;
  localparam int POS_LOCK  = 3;
  localparam int POS_LOCKF = 4;
  localparam int POS_LVR   = 5;

  typedef enum logic [1:0] {
    FL_LOCKCHG = 2'd0,
    FL_OSCCHG  = 2'd1,
    FL_LVR     = 2'd2,
    FL_ILA     = 2'd3
  } flag_id_e;

  function automatic int flag_pos(input int idx);
    case (idx)
      0:       return POS_LOCKF;
      1:       return POS_OSCF;
      2:       return POS_LVR;
      default: return POS_ILA;
    endcase
  endfunction
endpackage

// File: rtl/csf_sticky_flag.sv
module csf_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // A set in the same cycle as a clear leaves the flag high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/csf_status_track.sv
module csf_status_track (
  input  logic clk,
  input  logic rst_n,
  input  logic next_i,
  output logic sts_o,
  output logic chg_o
);
  // chg_o is high in the cycle before the register takes a new value
  assign chg_o = next_i ^ sts_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_o <= 1'b0;
    else        sts_o <= next_i;
  end
endmodule

// File: rtl/csf_clk_sel.sv
module csf_clk_sel #(
  parameter int POSTDIV_W = 5,
  parameter int SAFE_DIV  = 4,
  localparam int DIV_W    = POSTDIV_W + 1
) (
  input  logic                 lock_sts,
  input  logic                 osc_sts,
  input  logic [POSTDIV_W-1:0] postdiv_cfg,
  output logic [DIV_W-1:0]     pll_div_ratio,
  output logic                 can_osc_en
);
  localparam logic [DIV_W-1:0] SAFE_RATIO = DIV_W'(SAFE_DIV);

  logic [DIV_W-1:0] cfg_ratio;
  assign cfg_ratio = DIV_W'(postdiv_cfg) + DIV_W'(1);

  always_comb begin
    pll_div_ratio = lock_sts ? cfg_ratio : SAFE_RATIO;
    can_osc_en    = osc_sts;
  end
endmodule

// File: rtl/clk_stat_flags.sv
module clk_stat_flags #(
  parameter int POSTDIV_W = 5,
  parameter int SAFE_DIV  = 4,
  localparam int DIV_W    = POSTDIV_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr_en,
  input  logic [csf_pkg::REG_W-1:0] reg_wr_data,
  output logic [csf_pkg::REG_W-1:0] reg_rd_data,
  input  logic                     pll_lock_in,
  input  logic                     osc_qual_in,
  input  logic                     lvr_evt,
  input  logic                     iladdr_evt,
  input  logic                     full_stop,
  input  logic                     pseudo_stop,
  input  logic                     lock_ie,
  input  logic                     osc_ie,
  input  logic [POSTDIV_W-1:0]     postdiv_cfg,
  output logic [DIV_W-1:0]         pll_div_ratio,
  output logic                     can_osc_en,
  output logic                     irq
);
  import csf_pkg::*;

  logic lock_sts, lock_chg, osc_sts, osc_chg, osc_next;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

  // Oscillator qualification needs lock, except while pseudo stop is indicated
  assign osc_next = osc_qual_in & ~full_stop & (pll_lock_in | pseudo_stop);

  csf_status_track u_lock (
    .clk(clk), .rst_n(rst_n), .next_i(pll_lock_in),
    .sts_o(lock_sts), .chg_o(lock_chg)
  );

  csf_status_track u_osc (
    .clk(clk), .rst_n(rst_n), .next_i(osc_next),
    .sts_o(osc_sts), .chg_o(osc_chg)
  );

  assign flag_set[FL_LOCKCHG] = lock_chg;
  assign flag_set[FL_OSCCHG]  = osc_chg;
  assign flag_set[FL_LVR]     = lvr_evt;
  assign flag_set[FL_ILA]     = iladdr_evt;

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    assign flag_clr[gi] = reg_wr_en & reg_wr_data[flag_pos(gi)];
    csf_sticky_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(flag_set[gi]),
      .clr_i(flag_clr[gi]), .flag_o(flag_q[gi])
    );
  end

  // Write bits that map to no flag are ignored
  logic unused_wr_bits;
  assign unused_wr_bits = ^{reg_wr_data[REG_W-1:POS_LVR+1],
                            reg_wr_data[POS_LOCK], reg_wr_data[POS_OSC]};

  always_comb begin
    reg_rd_data            = '0;
    reg_rd_data[POS_OSC]   = osc_sts;
    reg_rd_data[POS_LOCK]  = lock_sts;
    for (int i = 0; i < NUM_FLAGS; i++)
      reg_rd_data[flag_pos(i)] = flag_q[i];
  end

  assign irq = (flag_q[FL_LOCKCHG] & lock_ie) | (flag_q[FL_OSCCHG] & osc_ie);

  csf_clk_sel #(.POSTDIV_W(POSTDIV_W), .SAFE_DIV(SAFE_DIV)) u_clk_sel (
    .lock_sts(lock_sts), .osc_sts(osc_sts), .postdiv_cfg(postdiv_cfg),
    .pll_div_ratio(pll_div_ratio), .can_osc_en(can_osc_en)
  );
endmodule

// File: rtl/csf_checker.sv
module csf_checker #(
  parameter int POSTDIV_W = 5,
  parameter int SAFE_DIV  = 4,
  localparam int DIV_W    = POSTDIV_W + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr_en,
  input logic [7:0]           reg_wr_data,
  input logic [7:0]           reg_rd_data,
  input logic                 pll_lock_in,
  input logic                 osc_qual_in,
  input logic                 lvr_evt,
  input logic                 iladdr_evt,
  input logic                 full_stop,
  input logic                 pseudo_stop,
  input logic                 lock_ie,
  input logic                 osc_ie,
  input logic [POSTDIV_W-1:0] postdiv_cfg,
  input logic [DIV_W-1:0]     pll_div_ratio,
  input logic                 can_osc_en,
  input logic                 irq
);
  // R1
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[7:6] == 2'b00);

  // R2
  lock_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> reg_rd_data[3] == $past(pll_lock_in));

  // R3
  osc_drop_on_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_lock_in && !pseudo_stop) |=> !reg_rd_data[0]);

  // R3
  osc_drop_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_stop |=> !reg_rd_data[0]);

  // R4
  lock_change_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[3] != $past(reg_rd_data[3])) |-> reg_rd_data[4]);

  // R5
  osc_change_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[0] != $past(reg_rd_data[0])) |-> reg_rd_data[1]);

  // R6
  lvr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvr_evt |=> reg_rd_data[5]);

  // R7
  lvr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[5] && !(reg_wr_en && reg_wr_data[5])) |=> reg_rd_data[5]);

  // R7
  ila_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_data[2] && !iladdr_evt) |=> !reg_rd_data[2]);

  // R8
  ila_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_data[2] && iladdr_evt) |=> reg_rd_data[2]);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (reg_rd_data[4] || reg_rd_data[1]));

  // R10
  safe_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_data[3] |-> pll_div_ratio == DIV_W'(SAFE_DIV));

  // R11
  can_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_data[0] |-> !can_osc_en);

  logic unused_chk;
  assign unused_chk = ^{osc_qual_in, lock_ie, osc_ie, postdiv_cfg};
endmodule

bind clk_stat_flags csf_checker #(.POSTDIV_W(POSTDIV_W), .SAFE_DIV(SAFE_DIV)) chk_i (.*);

// File: tb/clk_stat_flags_tb.sv
`timescale 1ns/1ps
module clk_stat_flags_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic       reg_wr_en = 0;
  logic [7:0] reg_wr_data = 0;
  logic [7:0] reg_rd_data;
  logic pll_lock_in = 0, osc_qual_in = 0, lvr_evt = 0, iladdr_evt = 0;
  logic full_stop = 0, pseudo_stop = 0, lock_ie = 0, osc_ie = 0;
  logic [4:0] postdiv_cfg = 5'd3;
  logic [5:0] pll_div_ratio;
  logic can_osc_en, irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic m_lock = 0, m_osc = 0, m_lockf = 0, m_oscf = 0, m_lvr = 0, m_ila = 0;

  always #5 clk = ~clk;

  clk_stat_flags dut_i (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    return {2'b00, m_lvr, m_lockf, m_lock, m_ila, m_oscf, m_osc};
  endfunction

  function automatic logic exp_irq();
    return (m_lockf & lock_ie) | (m_oscf & osc_ie);
  endfunction

  function automatic logic [5:0] exp_div();
    return m_lock ? 6'(postdiv_cfg) + 6'd1 : 6'd4;
  endfunction

  task automatic check_all();
    chk({6'd0, reg_rd_data[7:6]}, 8'd0, "R1");
    chk({7'd0, reg_rd_data[3]}, {7'd0, m_lock}, "R2");
    chk({7'd0, reg_rd_data[0]}, {7'd0, m_osc}, "R3");
    chk({7'd0, reg_rd_data[4]}, {7'd0, m_lockf}, "R4");
    chk({7'd0, reg_rd_data[1]}, {7'd0, m_oscf}, "R5");
    chk({6'd0, reg_rd_data[5], reg_rd_data[2]}, {6'd0, m_lvr, m_ila}, "R6/R7/R8");
    chk({7'd0, irq}, {7'd0, exp_irq()}, "R9");
    chk({2'd0, pll_div_ratio}, {2'd0, exp_div()}, "R10");
    chk({7'd0, can_osc_en}, {7'd0, m_osc}, "R11");
  endtask

  // One clock: model the edge from the inputs now applied, then check
  task automatic step();
    logic w5, w4, w2, w1, on;
    w5 = reg_wr_en & reg_wr_data[5];
    w4 = reg_wr_en & reg_wr_data[4];
    w2 = reg_wr_en & reg_wr_data[2];
    w1 = reg_wr_en & reg_wr_data[1];
    on = osc_qual_in & ~full_stop & (pll_lock_in | pseudo_stop);
    @(posedge clk);
    #1;
    m_lockf = (pll_lock_in != m_lock) | (m_lockf & ~w4);
    m_oscf  = (on != m_osc) | (m_oscf & ~w1);
    m_lvr   = lvr_evt | (m_lvr & ~w5);
    m_ila   = iladdr_evt | (m_ila & ~w2);
    m_lock  = pll_lock_in;
    m_osc   = on;
    reg_wr_en = 0; lvr_evt = 0; iladdr_evt = 0;
    check_all();
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr_en = 1; reg_wr_data = d;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
  end

  initial begin
    int seed;
    logic b;
    seed = 17;
    b = 1'($urandom(seed));
    #23 rst_n = 1;
    #1;
    // R12: reset state
    chk(reg_rd_data, 8'h00, "R12");
    chk({7'd0, irq}, 8'h00, "R12");

    // Lock rises, then oscillator qualifies
    pll_lock_in = 1; step();
    osc_qual_in = 1; step();
    // R4 R5 both flags set; enable interrupts
    lock_ie = 1; osc_ie = 1; #0 check_all();
    // R7: writing 0 leaves flags; writes to status bits ignored (R2, R3)
    wr(8'hC9); step();
    wr(8'h00); step();
    // R7: clear both change flags
    wr(8'h12); step();
    chk({7'd0, irq}, 8'h00, "R9 cleared");
    // R8: set and clear in same cycle
    lvr_evt = 1; iladdr_evt = 1; wr(8'h24); step();
    chk({6'd0, reg_rd_data[5], reg_rd_data[2]}, 8'h03, "R8 set wins");
    wr(8'h24); step();
    // R3: pseudo stop keeps oscillator status through loss of lock
    pseudo_stop = 1; pll_lock_in = 0; step();
    chk({7'd0, reg_rd_data[0]}, 8'h01, "R3 pseudo stop");
    chk({2'd0, pll_div_ratio}, 8'd4, "R10 safe ratio");
    pseudo_stop = 0; step();
    // R3: full stop while locked drops qualification
    pll_lock_in = 1; step(); step();
    full_stop = 1; step();
    chk({7'd0, can_osc_en}, 8'h00, "R11 full stop");
    full_stop = 0; step();
    postdiv_cfg = 5'd31; step();

    // Random phase
    for (int i = 0; i < 3000 && !done; i++) begin
      if ($urandom % 6 == 0) pll_lock_in = ~pll_lock_in;
      if ($urandom % 5 == 0) osc_qual_in = ~osc_qual_in;
      full_stop   = ($urandom % 16 == 0);
      pseudo_stop = ($urandom % 4 == 0);
      lvr_evt     = ($urandom % 20 == 0);
      iladdr_evt  = ($urandom % 20 == 0);
      lock_ie     = 1'($urandom);
      osc_ie      = 1'($urandom);
      postdiv_cfg = 5'($urandom);
      if ($urandom % 3 == 0) wr(8'($urandom));
      step();
    end
    done = 1;
  end

  initial begin
    wait (done);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule